// File: doc/BRIEF.md
# Configurable Audio Frequency Divider Network

This block holds four 8-bit divide-by-N counters, one for each channel of a four-voice sound generator. Each counter counts down on its own tick enable. When it expires it reloads from its own frequency register and emits a pulse one master-clock cycle wide. These pulses are the pitch clocks that the later tone and noise stages use. Those later stages are not part of this block.

A shared routing byte selects the tick source for each divider. By default all four dividers run from one of two slow base rates. Both base rates are single-cycle enables produced by prescaling the master clock (by 28 and by 114 by default), so there are no derived clocks. Dividers 1 and 3 can each be moved to the full master rate. Dividers 2 and 4 can each be chained, so that they count the pulses of divider 1 or divider 3. A chained pair gives a long period: the products of two 8-bit dividers, which is the range of a 16-bit divider. The four channels can therefore be grouped as four 8-bit voices, as two 16-bit voices, or as one 16-bit voice plus two 8-bit voices.

Software writes registers through a single write port. Addresses 0 to 3 hold the frequency values and address 4 holds the routing byte.

Top module: `audio_divnet`

## Requirements
- R1: A synchronous reset clears every counter, every frequency register and the routing byte. All pulse outputs are low in the cycle after a reset cycle. After reset, every divider pulses once every FAST_DIV master cycles.
- R2: A write with `wr_addr` 0, 1, 2 or 3 sets the frequency value of divider 1, 2, 3 or 4. A write with `wr_addr` 4 sets the routing byte. Writes to addresses 5 to 7 change nothing.
- R3: Routing bit 0 picks the base rate: 0 selects one tick every FAST_DIV cycles and 1 selects one tick every SLOW_DIV cycles. A divider at the base rate with value N pulses every (N+1)·base cycles.
- R4: Routing bit 6 set runs divider 1 at the master rate, so it pulses every N+1 cycles.
- R5: Routing bit 5 set runs divider 3 at the master rate, so it pulses every N+1 cycles.
- R6: Routing bit 4 set makes divider 2 count the pulses of divider 1. Its period is then (N1+1)·(N2+1) ticks of divider 1's source.
- R7: Routing bit 3 set makes divider 4 count the pulses of divider 3. Its period is then (N3+1)·(N4+1) ticks of divider 3's source.
- R8: A pulse is high only in the cycle after a tick that found its counter at zero. When the period is longer than one cycle, each pulse lasts exactly one cycle.
- R9: A write to a frequency register does not restart the counter. The count in progress finishes with the old value, and the new value is loaded at the next reload.
- R10: Both pairs route independently. The 16+8+8 and 16+16 groupings run at the same time with the periods given by R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0-3 frequency, 4 routing |
| wr_data | input | CW (8) | Write data |
| div_pulse | output | 4 | Divider pulses; bit 0 is divider 1 |

## Verification
The hardest case to reach from the ports is a frequency write that lands in the middle of a count. The old count must finish unchanged, and only the following period may use the new value. The bench reaches this case by waiting for a pulse, letting a fixed number of cycles pass, and then writing. It measures the gap to the next pulse and the gap after that. Chained periods are products of two dividers and can grow long. To keep them short enough to sweep, the bench shrinks both prescalers.

// File: rtl/divnet_pkg.sv
package divnet_pkg;
  localparam int NPAIR = 2;
  localparam int NCH   = 2 * NPAIR;

  typedef struct packed {
    logic             slow;        // base rate select
    logic [NPAIR-1:0] fast_low;    // low divider of pair at master rate
    logic [NPAIR-1:0] chain_high;  // high divider of pair counts low pulses
  } route_t;

  // upper = routing bits 6..3, slow = routing bit 0
  function automatic route_t decode_route(input logic [3:0] upper, input logic slow);
    route_t r;
    r.slow          = slow;
    r.fast_low[0]   = upper[3];
    r.fast_low[1]   = upper[2];
    r.chain_high[0] = upper[1];
    r.chain_high[1] = upper[0];
    return r;
  endfunction
endpackage

// File: rtl/divnet_prescale.sv
module divnet_prescale #(
  parameter int DIV = 28
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/divnet_route.sv
module divnet_route
  import divnet_pkg::*;
(
  input  route_t           route,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic [NPAIR-1:0] low_pulse,
  output logic [NCH-1:0]   tick
);
  logic base_tick;

  assign base_tick = route.slow ? slow_tick : fast_tick;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign tick[2*p]   = route.fast_low[p]   ? 1'b1         : base_tick;
    assign tick[2*p+1] = route.chain_high[p] ? low_pulse[p] : base_tick;
  end
endmodule

// File: rtl/divnet_cell.sv
module divnet_cell #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          pulse
);
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] rl);
    return (cur == '0) ? rl : cur - 1'b1;
  endfunction

  function automatic logic expires(input logic t, input logic [CW-1:0] cur);
    return t && (cur == '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= expires(tick, count);
      if (tick) count <= step_count(count, reload);
    end
  end
endmodule

// File: rtl/audio_divnet.sv
module audio_divnet
  import divnet_pkg::*;
#(
  parameter int CW       = 8,
  parameter int FAST_DIV = 28,
  parameter int SLOW_DIV = 114
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [3:0]    div_pulse
);
  localparam logic [2:0] ROUTE_ADDR = 3'd4;

  logic                   fast_tick;
  logic                   slow_tick;
  logic [NCH-1:0]         div_tick;
  logic [NCH-1:0][CW-1:0] div_count;
  logic [NCH-1:0][CW-1:0] freq_q;
  logic [NPAIR-1:0]       low_pulse;
  route_t                 route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (wr_addr < ROUTE_ADDR)
        freq_q[wr_addr[1:0]] <= wr_data;
      else if (wr_addr == ROUTE_ADDR)
        route_q <= decode_route(wr_data[6:3], wr_data[0]);
    end
  end

  divnet_prescale #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .tick(fast_tick));
  divnet_prescale #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .tick(slow_tick));

  for (genvar p = 0; p < NPAIR; p++) begin : g_low
    assign low_pulse[p] = div_pulse[2*p];
  end

  divnet_route u_route (
    .route    (route_q),
    .fast_tick(fast_tick),
    .slow_tick(slow_tick),
    .low_pulse(low_pulse),
    .tick     (div_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cell
    divnet_cell #(.CW(CW)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .tick  (div_tick[c]),
      .reload(freq_q[c]),
      .count (div_count[c]),
      .pulse (div_pulse[c])
    );
  end
endmodule

// File: rtl/divnet_chk.sv
module divnet_chk
  import divnet_pkg::*;
#(
  parameter int CW = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCH-1:0]         div_pulse,
  input logic [NCH-1:0]         div_tick,
  input logic [NCH-1:0][CW-1:0] div_count,
  input logic [NCH-1:0][CW-1:0] freq_q,
  input route_t                 route_q
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (div_pulse == '0)) else $error("reset quiet"); // R1

  AST_CHAIN_PAIR_LOW: assert property (@(posedge clk) disable iff (rst)
    (div_pulse[1] && $past(route_q.chain_high[0])) |-> $past(div_pulse[0]))
    else $error("chain pair 1/2"); // R6

  AST_CHAIN_PAIR_HIGH: assert property (@(posedge clk) disable iff (rst)
    (div_pulse[3] && $past(route_q.chain_high[1])) |-> $past(div_pulse[2]))
    else $error("chain pair 3/4"); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
      div_pulse[i] |-> $past(div_tick[i])) else $error("pulse without tick"); // R8

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
      (div_tick[i] && div_count[i] != '0) |=> (div_count[i] == $past(div_count[i]) - 1'b1))
      else $error("count step"); // R9

    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (div_tick[i] && div_count[i] == '0) |=> (div_count[i] == $past(freq_q[i])))
      else $error("reload"); // R9
  end
endmodule

bind audio_divnet divnet_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .div_pulse(div_pulse),
  .div_tick (div_tick),
  .div_count(div_count),
  .freq_q   (freq_q),
  .route_q  (route_q)
);

// File: tb/audio_divnet_test.sv
`timescale 1ns/1ps
module audio_divnet_test;
  localparam int FD = 4;
  localparam int SD = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] div_pulse;

  int ncmp = 0;
  int nbad = 0;
  int cyc = 0;
  int last_t[4];
  int prev_t[4];
  int npulse[4];
  int run[4];
  int maxrun[4];

  always #10 clk = ~clk;

  audio_divnet #(.CW(8), .FAST_DIV(FD), .SLOW_DIV(SD)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_pulse(div_pulse)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    for (int i = 0; i < 4; i++) begin
      if (div_pulse[i]) begin
        prev_t[i] = last_t[i];
        last_t[i] = cyc;
        npulse[i]++;
        run[i]++;
        if (run[i] > maxrun[i]) maxrun[i] = run[i];
      end else begin
        run[i] = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_freqs(input int f0, input int f1, input int f2, input int f3);
    wr(3'd0, 8'(f0)); wr(3'd1, 8'(f1)); wr(3'd2, 8'(f2)); wr(3'd3, 8'(f3));
  endtask

  task automatic interval(input int ch, output int iv);
    int c0;
    c0 = npulse[ch];
    while (npulse[ch] < c0 + 3) @(negedge clk);
    iv = last_t[ch] - prev_t[ch];
  endtask

  task automatic expect_iv(input string tag, input int ch, input int exp);
    int iv;
    interval(ch, iv);
    check(tag, iv, exp);
  endtask

  function automatic int base_of(input bit slow);
    return slow ? SD : FD;
  endfunction

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    int t0;
    int c0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pulses during reset", int'(div_pulse), 0);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) expect_iv("R1 post-reset period", c, FD);

    // R3: fast base rate, distinct values
    set_freqs(3, 10, 0, 255);
    wr(3'd4, 8'h00);
    expect_iv("R3 fast d1", 0, 4 * base_of(0));
    expect_iv("R3 fast d2", 1, 11 * base_of(0));
    expect_iv("R3 fast d3", 2, 1 * base_of(0));
    expect_iv("R3 fast d4", 3, 256 * base_of(0));

    // R3: slow base rate
    set_freqs(2, 7, 20, 100);
    wr(3'd4, 8'h01);
    expect_iv("R3 slow d1", 0, 3 * base_of(1));
    expect_iv("R3 slow d2", 1, 8 * base_of(1));
    expect_iv("R3 slow d3", 2, 21 * base_of(1));
    expect_iv("R3 slow d4", 3, 101 * base_of(1));

    // R4: divider 1 at master rate, sweep
    set_freqs(0, 4, 0, 0);
    wr(3'd4, 8'h40);
    for (int n = 0; n < 256; n += 3) begin
      wr(3'd0, 8'(n));
      expect_iv("R4 master d1", 0, n + 1);
    end
    wr(3'd0, 8'd255);
    expect_iv("R4 master d1 max", 0, 256);
    expect_iv("R4 d2 stays on base", 1, 5 * FD);

    // R5: divider 3 at master rate
    wr(3'd4, 8'h20);
    for (int n = 0; n < 256; n += 17) begin
      wr(3'd2, 8'(n));
      expect_iv("R5 master d3", 2, n + 1);
    end
    expect_iv("R5 d1 back on base", 0, 256 * FD);

    // R6: divider 2 chained to master-rate divider 1
    wr(3'd4, 8'h50);
    for (int l = 0; l < 5; l += 2) begin
      for (int h = 0; h < 10; h += 3) begin
        wr(3'd0, 8'(l)); wr(3'd1, 8'(h));
        expect_iv("R6 chain master", 1, (l + 1) * (h + 1));
      end
    end
    wr(3'd4, 8'h10);
    wr(3'd0, 8'd2); wr(3'd1, 8'd3);
    expect_iv("R6 chain base", 1, 3 * 4 * FD);

    // R7: divider 4 chained to divider 3
    wr(3'd4, 8'h28);
    for (int l = 0; l < 5; l += 2) begin
      for (int h = 0; h < 10; h += 3) begin
        wr(3'd2, 8'(l)); wr(3'd3, 8'(h));
        expect_iv("R7 chain master", 3, (l + 1) * (h + 1));
      end
    end
    wr(3'd4, 8'h09);
    wr(3'd2, 8'd1); wr(3'd3, 8'd2);
    expect_iv("R7 chain slow base", 3, 2 * 3 * SD);

    // R10: 16 + 8 + 8 grouping
    set_freqs(5, 7, 6, 11);
    wr(3'd4, 8'h50);
    expect_iv("R10 16bit pair", 1, 6 * 8);
    expect_iv("R10 8bit d3", 2, 7 * FD);
    expect_iv("R10 8bit d4", 3, 12 * FD);
    // R10: 16 + 16 grouping
    wr(3'd4, 8'h78);
    expect_iv("R10 pair A", 1, 6 * 8);
    expect_iv("R10 pair B", 3, 7 * 12);

    // R8: one-cycle pulses
    set_freqs(3, 0, 9, 2);
    wr(3'd4, 8'h40);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) maxrun[i] = 0;
    expect_iv("R8 period d1", 0, 4);
    expect_iv("R8 period d2", 1, FD);
    check("R8 width d1", maxrun[0], 1);
    check("R8 width d2", maxrun[1], 1);

    // R2: unused addresses ignored
    wr(3'd0, 8'd9);
    expect_iv("R2 baseline", 0, 10);
    wr(3'd5, 8'h00); wr(3'd6, 8'hFF); wr(3'd7, 8'h01);
    expect_iv("R2 ignored writes d1", 0, 10);
    expect_iv("R2 ignored writes d2", 1, FD);

    // R9: mid-count write does not restart
    wr(3'd0, 8'd200);
    expect_iv("R9 setup", 0, 201);
    c0 = npulse[0];
    while (npulse[0] == c0) @(negedge clk);
    t0 = last_t[0];
    repeat (10) @(negedge clk);
    wr(3'd0, 8'd5);
    c0 = npulse[0];
    while (npulse[0] == c0) @(negedge clk);
    check("R9 old count completes", last_t[0] - t0, 201);
    t0 = last_t[0];
    c0 = npulse[0];
    while (npulse[0] == c0) @(negedge clk);
    check("R9 new value after reload", last_t[0] - t0, 6);

    // R1: reset in the middle of operation
    set_freqs(40, 30, 20, 10);
    wr(3'd4, 8'h79);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 pulses after mid reset", int'(div_pulse), 0);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) expect_iv("R1 cleared period", c, FD);

    summary_and_end();
  end
endmodule